// File: doc/BRIEF.md
# One-Wire Bus Master Controller

This block masters a single open-drain 1-wire bus from a small bank of 16-bit registers. It pulls the bus low through one output, reads the bus level back through one input, and times every pulse in ticks of roughly 1 µs. A programmable prescaler derives these ticks from the system clock.

The bus is driven in two ways. In bit mode, software writes a self-clearing start bit in the control register. The bit selects a bus reset with presence detection, a write-0 slot, or a write-1/read slot. Software then polls until the bit reads back 0 and collects the sampled result from the same register. In byte mode, a write to the data register runs eight slots on its own, least significant bit first. Transmit and receive flags in a status register follow the transfer, and an interrupt output reports the flags that software has enabled.

Register word addresses: 0 control, 1 tick divider, 2 and 3 reserved, 4 data, 5 status, 6 interrupt enable.

Top module: `onewire_master`

## Requirements
- R1: After reset, control reads 0x0000, status reads 0x000C (bits 2 and 3 set), divider and interrupt enable read 0, `bus_pull_low` is 0 and `irq` is 0.
- R2: The divider register (address 1) holds N−1 and produces one timing tick every N clock cycles.
- R3: Writing control bit 7 starts a bus reset. The bus is held low for 480 ticks, and bit 7 reads 1 until the sequence ends 480 ticks after release, then reads 0. When several start bits are written together, reset takes priority over write-0, and write-0 over write-1.
- R4: When a bus reset ends, control bit 6 holds the bus level sampled 70 ticks after release. It reads 0 when a device answered and 1 when none did.
- R5: Control bit 5 starts a write-0 slot that is low for 60 ticks. Control bit 4 starts a write-1/read slot that is low for 2 ticks. Each slot lasts 65 ticks, and its start bit clears when the slot ends.
- R6: Control bit 3 holds the bus level sampled 15 ticks into the most recent bit-mode write-1/read slot.
- R7: Writing a byte to the data register (address 4) sends eight slots, LSB first. A 0 bit uses a write-0 slot and a 1 bit uses a write-1 slot.
- R8: The level sampled in each byte-mode slot is shifted in LSB first. After the eighth slot, the data register reads the received byte in bits 7:0, with bits 15:8 reading 0. Writing 0xFF therefore performs a byte read.
- R9: Status (address 5) has four flags: bit 2 transmit buffer empty, bit 3 transmit shift register empty, bit 4 receive full, bit 5 receive shift register full. A data write clears bits 2, 3 and 5 and keeps bit 4. Completion of the eighth slot sets all four. Reading the data register clears bit 4. If that read falls in the cycle the byte completes, bit 4 stays set.
- R10: `irq` is high exactly when some status flag is set whose matching bit in the interrupt enable register (address 6, bits 5:2) is set.
- R11: A control or data write that would start an operation while a bit operation or byte transfer is running is ignored. The control start bits stay 0 during a byte transfer, and the byte on the bus is unchanged.
- R12: Addresses 2, 3 and 7 read 0, and writes to them change no register.
- R13: `bus_pull_low` is asserted only during the low phase of an active reset or slot. `bus_in` is sampled through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| bus_in | input | 1 | Level of the 1-wire bus |
| bus_pull_low | output | 1 | High to pull the bus low, otherwise released |
| irq | output | 1 | Enabled status flags ORed |

## Verification
Two functions can fall in the same cycle. The first pair is a new start request arriving while a byte transfer still owns the slot engine. The bench provokes this by writing the control reset bit and then a second data byte in the middle of a transfer. It judges the result at the ports: the control register must read 0, and the device model must capture the original byte. The second pair is a data-register read coinciding with byte completion. An assertion covers it by requiring the receive-full flag to be set in the cycle after the last slot, whatever read accompanied it.

// File: rtl/ow_pkg.sv
package ow_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_RESET = 2'd1,
    OP_W0    = 2'd2,
    OP_W1    = 2'd3
  } ow_op_e;

  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_DIV  = 1;
  localparam int unsigned A_DATA = 4;
  localparam int unsigned A_STAT = 5;
  localparam int unsigned A_IEN  = 6;
endpackage

// File: rtl/ow_tick_gen.sv
module ow_tick_gen #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q >= div);

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0 && $stable(div)) |=> !tick); // R2
endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine
  import ow_pkg::*;
#(
  parameter int RST_LOW    = 480,
  parameter int RST_SAMPLE = 70,
  parameter int RST_WAIT   = 480,
  parameter int W0_LOW     = 60,
  parameter int W1_LOW     = 2,
  parameter int RD_SAMPLE  = 15,
  parameter int SLOT_LEN   = 65
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   start,
  input  ow_op_e start_op,
  input  logic   line_s,
  output logic   pull_low,
  output logic   busy,
  output logic   done,
  output ow_op_e cur_op,
  output logic   sample
);
  localparam int CW = $clog2(RST_LOW + RST_WAIT + 1);

  ow_op_e        op_q, op_d;
  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          smp_q, smp_d;
  logic [CW-1:0] low_len, smp_pt, end_pt;

  always_comb begin
    case (op_q)
      OP_RESET: begin
        low_len = CW'(RST_LOW);
        smp_pt  = CW'(RST_LOW + RST_SAMPLE);
        end_pt  = CW'(RST_LOW + RST_WAIT);
      end
      OP_W0: begin
        low_len = CW'(W0_LOW);
        smp_pt  = CW'(RD_SAMPLE);
        end_pt  = CW'(SLOT_LEN);
      end
      default: begin
        low_len = CW'(W1_LOW);
        smp_pt  = CW'(RD_SAMPLE);
        end_pt  = CW'(SLOT_LEN);
      end
    endcase
  end

  assign done     = busy_q && tick && (cnt_q == end_pt - 1'b1);
  assign pull_low = busy_q && (cnt_q < low_len);
  assign busy     = busy_q;
  assign cur_op   = op_q;
  assign sample   = smp_q;

  always_comb begin
    op_d   = op_q;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    smp_d  = smp_q;
    if (!busy_q) begin
      if (start) begin
        op_d   = start_op;
        busy_d = 1'b1;
        cnt_d  = '0;
      end
    end else if (tick) begin
      if (cnt_q == smp_pt) smp_d = line_s;
      if (done) busy_d = 1'b0;
      else      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      smp_q  <= 1'b1;
    end else begin
      op_q   <= op_d;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      smp_q  <= smp_d;
    end
  end

  AST_DRIVE_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    pull_low |-> busy_q); // R13
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < end_pt)); // R5
endmodule

// File: rtl/onewire_master.sv
module onewire_master
  import ow_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          bus_in,
  output logic          bus_pull_low,
  output logic          irq
);
  localparam int BCW = $clog2(BW + 1);

  logic line_s1, line_s2;
  logic tick;
  logic eng_start, eng_busy, eng_done, eng_smp;
  ow_op_e eng_op, eng_cur;

  logic [DW-1:0]  div_q, div_d;
  logic           rpp_q, rpp_d, w0_q, w0_d, w1_q, w1_d;
  logic           pst_q, pst_d, rdst_q, rdst_d;
  logic           bact_q, bact_d;
  logic [BCW-1:0] bits_q, bits_d;
  logic [BW-1:0]  sh_q, sh_d, rx_q, rx_d;
  logic           tbe_q, tbe_d, tsre_q, tsre_d, rbf_q, rbf_d, rsrf_q, rsrf_d;
  logic [3:0]     ien_q, ien_d;

  logic idle, wr_ctrl, ctrl_go, data_go, slot_go, byte_end;

  ow_tick_gen #(.DW(DW)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick)
  );

  ow_slot_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(eng_start),
    .start_op(eng_op), .line_s(line_s2), .pull_low(bus_pull_low),
    .busy(eng_busy), .done(eng_done), .cur_op(eng_cur), .sample(eng_smp)
  );

  assign idle     = !eng_busy && !bact_q && !(rpp_q || w0_q || w1_q);
  assign wr_ctrl  = reg_wr && (reg_addr == AW'(A_CTRL));
  assign ctrl_go  = wr_ctrl && idle && (reg_wdata[7] || reg_wdata[5] || reg_wdata[4]);
  assign data_go  = reg_wr && (reg_addr == AW'(A_DATA)) && idle;
  assign slot_go  = bact_q && !eng_busy && !eng_done && (bits_q != '0);
  assign byte_end = eng_done && bact_q && (bits_q == BCW'(1));

  assign eng_start = ctrl_go || slot_go;
  always_comb begin
    if (ctrl_go) begin
      if (reg_wdata[7])      eng_op = OP_RESET;
      else if (reg_wdata[5]) eng_op = OP_W0;
      else                   eng_op = OP_W1;
    end else begin
      eng_op = sh_q[0] ? OP_W1 : OP_W0;
    end
  end

  always_comb begin
    div_d = div_q;  ien_d = ien_q;
    rpp_d = rpp_q;  w0_d = w0_q;  w1_d = w1_q;
    pst_d = pst_q;  rdst_d = rdst_q;
    bact_d = bact_q; bits_d = bits_q; sh_d = sh_q; rx_d = rx_q;
    tbe_d = tbe_q;  tsre_d = tsre_q; rbf_d = rbf_q; rsrf_d = rsrf_q;

    if (reg_wr && reg_addr == AW'(A_DIV)) div_d = reg_wdata;
    if (reg_wr && reg_addr == AW'(A_IEN)) ien_d = reg_wdata[5:2];

    if (ctrl_go) begin
      rpp_d = (eng_op == OP_RESET);
      w0_d  = (eng_op == OP_W0);
      w1_d  = (eng_op == OP_W1);
    end
    if (eng_done && !bact_q) begin
      rpp_d = 1'b0; w0_d = 1'b0; w1_d = 1'b0;
      if (eng_cur == OP_RESET) pst_d  = eng_smp;
      if (eng_cur == OP_W1)    rdst_d = eng_smp;
    end

    if (reg_rd && reg_addr == AW'(A_DATA)) rbf_d = 1'b0;
    if (data_go) begin
      bact_d = 1'b1;
      bits_d = BCW'(BW);
      sh_d   = reg_wdata[BW-1:0];
      tbe_d  = 1'b0; tsre_d = 1'b0; rsrf_d = 1'b0;
    end
    if (eng_done && bact_q) begin
      sh_d   = {eng_smp, sh_q[BW-1:1]};
      bits_d = bits_q - 1'b1;
      if (byte_end) begin
        bact_d = 1'b0;
        rx_d   = {eng_smp, sh_q[BW-1:1]};
        tbe_d  = 1'b1; tsre_d = 1'b1; rbf_d = 1'b1; rsrf_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_s1 <= 1'b1;  line_s2 <= 1'b1;
      div_q <= '0;  ien_q <= '0;
      rpp_q <= 1'b0; w0_q <= 1'b0; w1_q <= 1'b0;
      pst_q <= 1'b0; rdst_q <= 1'b0;
      bact_q <= 1'b0; bits_q <= '0; sh_q <= '0; rx_q <= '0;
      tbe_q <= 1'b1; tsre_q <= 1'b1; rbf_q <= 1'b0; rsrf_q <= 1'b0;
    end else begin
      line_s1 <= bus_in; line_s2 <= line_s1;
      div_q <= div_d;  ien_q <= ien_d;
      rpp_q <= rpp_d;  w0_q <= w0_d;  w1_q <= w1_d;
      pst_q <= pst_d;  rdst_q <= rdst_d;
      bact_q <= bact_d; bits_q <= bits_d; sh_q <= sh_d; rx_q <= rx_d;
      tbe_q <= tbe_d;  tsre_q <= tsre_d; rbf_q <= rbf_d; rsrf_q <= rsrf_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(A_CTRL): reg_rdata[7:3] = {rpp_q, pst_q, w0_q, w1_q, rdst_q};
      AW'(A_DIV):  reg_rdata      = div_q;
      AW'(A_DATA): reg_rdata[BW-1:0] = rx_q;
      AW'(A_STAT): reg_rdata[5:2] = {rsrf_q, rbf_q, tsre_q, tbe_q};
      AW'(A_IEN):  reg_rdata[5:2] = ien_q;
      default:     reg_rdata      = '0;
    endcase
  end

  assign irq = |({rsrf_q, rbf_q, tsre_q, tbe_q} & ien_q);

  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !eng_busy); // R11
  AST_BYTE_NO_BITOP: assert property (@(posedge clk) disable iff (!rst_n)
    bact_q |-> !(rpp_q || w0_q || w1_q)); // R11
  AST_BIT_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !bact_q) |=> !(rpp_q || w0_q || w1_q)); // R5
  AST_RX_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    byte_end |=> (rbf_q && rsrf_q && tsre_q)); // R9
endmodule

// File: tb/onewire_master_bench.sv
module onewire_master_bench;
  logic        clk, rst_n;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        bus_in, bus_pull_low, irq;

  int errors = 0, checks = 0;
  bit finished = 0;

  // device model state
  bit   dev_en = 1;
  logic [7:0] reply = 8'hFF;
  logic [7:0] cap = 8'h00;
  int   P = 1;
  logic prev_dl = 0;
  int   mlow = 0, scnt = -1, rpull = 0, pcnt = -1, idx = 0;
  logic dev_pull;
  int   lowcnt = 0, last_low = 0;

  assign dev_pull = (rpull > 0) || (pcnt >= 10*P && pcnt < 110*P);
  assign bus_in   = !(bus_pull_low || dev_pull);

  onewire_master u_onewire_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_in(bus_in), .bus_pull_low(bus_pull_low), .irq(irq)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    prev_dl <= bus_pull_low;
    mlow    <= bus_pull_low ? mlow + 1 : 0;
    if (rpull > 0) rpull <= rpull - 1;
    if (pcnt >= 0) pcnt <= (pcnt >= 110*P) ? -1 : pcnt + 1;
    if (bus_pull_low && !prev_dl) begin
      scnt <= 0;
      if (dev_en && !reply[idx % 8]) rpull <= 40*P;
      idx <= idx + 1;
    end else if (scnt >= 0) begin
      if (scnt == 30*P) begin cap <= {bus_in, cap[7:1]}; scnt <= -1; end
      else scnt <= scnt + 1;
    end
    if (!bus_pull_low && prev_dl && mlow >= 300*P && dev_en) begin
      pcnt <= 0; idx <= 0;
    end
    if (bus_pull_low) lowcnt <= lowcnt + 1;
    else if (lowcnt > 0) begin last_low <= lowcnt; lowcnt <= 0; end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_low(string req, int len);
    int lo = (len - 1) * P + 1;
    int hi = len * P;
    checks++;
    if (last_low < lo || last_low > hi) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, last_low, lo, hi);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 3'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_rd = 1; reg_addr = 3'(a);
    #1 d = int'(reg_rdata);
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic wait_idle();
    int c, s;
    forever begin
      rd(0, c); rd(5, s);
      if ((c & 16'h00B0) == 0 && (s & 16'h0008) != 0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int v;
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, v); check("R1 ctrl", v, 0);
    rd(5, v); check("R1 status", v, 16'h000C);
    rd(1, v); check("R1 divider", v, 0);
    rd(6, v); check("R1 ien", v, 0);
    check("R1 pull", int'(bus_pull_low), 0);
    check("R1 irq", int'(irq), 0);

    // R2 divider of 2
    P = 2; wr(1, 1);
    rd(1, v); check("R2 divider readback", v, 1);

    // R3 / R4 reset with device
    wr(0, 16'h0080);
    rd(0, v); check("R3 busy bit", (v >> 7) & 1, 1);
    wait_idle();
    check_low("R3 reset low", 480);
    rd(0, v); check("R3 self clear", (v >> 7) & 1, 0);
    check("R4 presence", (v >> 6) & 1, 0);

    dev_en = 0;
    wr(0, 16'h0080); wait_idle();
    rd(0, v); check("R4 no device", (v >> 6) & 1, 1);
    dev_en = 1;

    // R3 priority: reset+write0 together runs a reset
    wr(0, 16'h00A0); wait_idle();
    check_low("R3 priority", 480);

    // R5 slots
    wr(0, 16'h0020); wait_idle();
    check_low("R5 write0 low", 60);
    rd(0, v); check("R5 write0 clear", v & 16'h0030, 0);
    reply = 8'hFF;
    wr(0, 16'h0010); wait_idle();
    check_low("R5 write1 low", 2);
    rd(0, v); check("R6 read one", (v >> 3) & 1, 1);
    reply = 8'h00;
    wr(0, 16'h0010); wait_idle();
    rd(0, v); check("R6 read zero", (v >> 3) & 1, 0);
    check("R5 write1 clear", v & 16'h0030, 0);

    // R2 larger divider
    P = 4; wr(1, 3);
    wr(0, 16'h0080); wait_idle();
    check_low("R2 divider 4", 480);

    // byte write sweep at tick per clock
    P = 1; wr(1, 0); reply = 8'hFF;
    wr(0, 16'h0080); wait_idle();
    for (int b = 0; b < 256; b += 3) begin
      wr(4, b); wait_idle();
      check("R7 byte sent", int'(cap), b);
      rd(4, v); check("R8 loopback", v, b);
    end

    // byte read sweep
    for (int b = 1; b < 256; b += 5) begin
      reply = 8'(b);
      wr(4, 16'h00FF); wait_idle();
      rd(4, v); check("R8 byte read", v, b);
    end

    // R9 flags
    reply = 8'hFF;
    wr(4, 16'h0033); wait_idle();
    rd(5, v); check("R9 complete", v, 16'h003C);
    wr(4, 16'h0044);
    rd(5, v); check("R9 in flight", v, 16'h0010);
    wait_idle();
    rd(4, v); check("R9 data", v, 16'h0044);
    rd(5, v); check("R9 read clears full", v, 16'h002C);

    // R10 interrupt
    wr(6, 16'h0010);
    rd(6, v); check("R10 enable readback", v, 16'h0010);
    @(negedge clk); check("R10 irq idle", int'(irq), 0);
    wr(4, 16'h0011); wait_idle();
    check("R10 irq set", int'(irq), 1);
    rd(4, v);
    @(negedge clk); check("R10 irq cleared", int'(irq), 0);
    wr(6, 0);

    // R11 starts ignored during byte
    wr(4, 16'h005A);
    repeat (40) @(negedge clk);
    wr(0, 16'h0080);
    rd(0, v); check("R11 ctrl ignored", v & 16'h00B0, 0);
    wr(4, 16'h0000);
    wait_idle();
    check("R11 byte intact", int'(cap), 16'h5A);
    rd(4, v); check("R11 data intact", v, 16'h5A);

    // R12 reserved addresses
    wr(2, 16'hFFFF); wr(3, 16'hFFFF); wr(7, 16'hFFFF);
    rd(2, v); check("R12 addr2", v, 0);
    rd(3, v); check("R12 addr3", v, 0);
    rd(7, v); check("R12 addr7", v, 0);
    rd(1, v); check("R12 divider kept", v, 0);
    rd(0, v); check("R12 ctrl kept", v & 16'h00B0, 0);

    // R13 released while idle
    repeat (20) @(negedge clk);
    check("R13 idle release", int'(bus_pull_low), 0);
    summary();
  end
endmodule